// File: doc/BRIEF.md
# Branch Direction and Target Predictor

This block sits in the fetch stage and answers two questions about the instruction at the current fetch address. It gives the direction, taken or not taken, and the next fetch address. Direction comes from a table of two-bit saturating counters. The next address comes from a table of remembered branch targets. Both tables are addressed by the same slice of the program counter. The lookup is purely combinational, so the prediction is ready in the cycle the fetch address is presented.

Once a branch resolves further down the pipeline, the resolved address, the real outcome and the real target are presented on the training port. The counter for that slot steps toward the outcome. A taken outcome also records its target. Branches whose addresses agree in the index bits share a slot and disturb one another; this interference is expected behaviour. Unconditional jumps are trained as taken outcomes, so their targets are predicted the same way as conditional ones.

Top module: `branch_pred`

## Requirements
- R1: In a cycle with reset asserted, every counter is set to the weakly-not-taken value 01, and every remembered target and its valid flag are cleared. After reset, every lookup reports not taken with a next address of lk_pc + 4.
- R2: The slot index is lk_pc[13:2] for a lookup and up_pc[13:2] for training. Addresses that differ only in bits 1:0, or only above bit 13, use the same slot.
- R3: lk_taken is 1 exactly when the slot's counter is 10 or 11.
- R4: A taken training event raises the counter by one and stops at 11. A not-taken training event lowers it by one and stops at 00.
- R5: Starting from 11, one not-taken event leaves the prediction at taken, and a second one turns it to not taken. Starting from 00, two taken events are likewise needed before taken is predicted.
- R6: A taken training event stores up_target[PC_W-1:2] in the slot and marks the slot valid; a later taken event replaces it. A not-taken event leaves the stored target unchanged. Bits 1:0 of a predicted target are always zero.
- R7: lk_target is the slot's stored target when lk_taken is 1 and the slot is valid; otherwise it is lk_pc + 4, wrapping modulo 2^PC_W.
- R8: A training event changes the lookup result from the next clock edge on. A lookup of the same slot in the same cycle as the training event sees the old contents; there is no bypass.
- R9: A training event changes no slot other than the one it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_pc | input | PC_W | Fetch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| lk_target | output | PC_W | Predicted next fetch address |
| up_valid | input | 1 | Training event present this cycle |
| up_pc | input | PC_W | Address of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |
| up_target | input | PC_W | Actual target of the resolved branch |

## Verification
The hardest case to reach from the ports is a training event and a lookup that hit the same slot in the same clock cycle. The bench drives both ports together on one falling edge. It samples the old prediction before the rising edge, then samples the new one a cycle later. The hysteresis of the counters is only visible after an exact sequence of outcomes. Each direction test therefore first saturates a slot through a known number of events, then walks it back one event at a time, checking the prediction after each step. Aliasing is shown by training one address and reading the prediction at another address that has a different high part but the same index bits.

// File: rtl/bp_pkg.sv
package bp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_STRONG_NT = 2'b00;
    localparam ctr_t CTR_WEAK_NT   = 2'b01;
    localparam ctr_t CTR_STRONG_T  = 2'b11;

    // Saturating step toward the observed outcome
    function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
        ctr_t nxt;
        nxt = cur;
        if (taken && cur != CTR_STRONG_T)
            nxt = cur + 2'd1;
        else if (!taken && cur != CTR_STRONG_NT)
            nxt = cur - 2'd1;
        return nxt;
    endfunction

    function automatic logic ctr_predicts(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/bp_dir_table.sv
module bp_dir_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t cnt_q [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++)
                cnt_q[i] <= CTR_WEAK_NT;
        end else if (wr_en) begin
            cnt_q[wr_idx] <= ctr_train(cnt_q[wr_idx], wr_taken);
        end
    end

    assign rd_taken = ctr_predicts(cnt_q[rd_idx]);

    // R4
    taken_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken) |=>
            ctr_t'(cnt_q[$past(wr_idx)] - $past(cnt_q[wr_idx])) <= 2'd1);

    // R4
    nt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken) |=>
            ctr_t'($past(cnt_q[wr_idx]) - cnt_q[$past(wr_idx)]) <= 2'd1);

    // R4
    ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_taken && cnt_q[wr_idx] == CTR_STRONG_T) |=>
            cnt_q[$past(wr_idx)] == CTR_STRONG_T);

    // R4
    floor_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_taken && cnt_q[wr_idx] == CTR_STRONG_NT) |=>
            cnt_q[$past(wr_idx)] == CTR_STRONG_NT);

endmodule

// File: rtl/bp_tgt_table.sv
module bp_tgt_table #(
    parameter int IDX_W = 12,
    parameter int TGT_W = 30
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TGT_W-1:0] rd_tgt,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TGT_W-1:0] wr_tgt
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [TGT_W-1:0]   tgt_q [ENTRIES];
    logic [ENTRIES-1:0] vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < ENTRIES; i++)
                tgt_q[i] <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    assign rd_valid = vld_q[rd_idx];
    assign rd_tgt   = tgt_q[rd_idx];

    // R6
    marks_valid_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> vld_q[$past(wr_idx)]);

    // R6
    holds_written_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> tgt_q[$past(wr_idx)] == $past(wr_tgt));

endmodule

// File: rtl/branch_pred.sv
module branch_pred
    import bp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_taken,
    output logic [PC_W-1:0] lk_target,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_taken,
    input  logic [PC_W-1:0] up_target
);
    localparam int ALIGN_W = 2;
    localparam int TGT_W   = PC_W - ALIGN_W;
    localparam int IDX_HI  = IDX_W + ALIGN_W - 1;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic             dir_taken, tgt_valid;
    logic [TGT_W-1:0] tgt_word;
    logic [PC_W-1:0]  seq_pc;
    logic             unused_bits;

    assign lk_idx = lk_pc[IDX_HI:ALIGN_W];
    assign up_idx = up_pc[IDX_HI:ALIGN_W];
    assign unused_bits = ^{up_pc[PC_W-1:IDX_HI+1], up_pc[ALIGN_W-1:0],
                           up_target[ALIGN_W-1:0]};

    bp_dir_table #(.IDX_W(IDX_W)) i_dir (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_taken (dir_taken),
        .wr_en    (up_valid),
        .wr_idx   (up_idx),
        .wr_taken (up_taken)
    );

    bp_tgt_table #(.IDX_W(IDX_W), .TGT_W(TGT_W)) i_tgt (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (lk_idx),
        .rd_valid (tgt_valid),
        .rd_tgt   (tgt_word),
        .wr_en    (up_valid && up_taken),
        .wr_idx   (up_idx),
        .wr_tgt   (up_target[PC_W-1:ALIGN_W])
    );

    assign seq_pc = lk_pc + PC_W'(4);

    always_comb begin
        lk_taken  = dir_taken;
        lk_target = seq_pc;
        if (dir_taken && tgt_valid)
            lk_target = {tgt_word, {ALIGN_W{1'b0}}};
    end

    // R1
    post_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!lk_taken && lk_target == lk_pc + PC_W'(4)));

    // R6
    aligned_tgt_chk: assert property (@(posedge clk) disable iff (rst)
        lk_taken |-> lk_target[ALIGN_W-1:0] == '0);

    // R8
    quiet_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(up_valid) && $stable(lk_pc)) |->
            ($stable(lk_taken) && $stable(lk_target)));

endmodule

// File: tb/test_branch_pred.sv
module test_branch_pred;
    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst;
    logic [PC_W-1:0] lk_pc;
    logic            lk_taken;
    logic [PC_W-1:0] lk_target;
    logic            up_valid;
    logic [PC_W-1:0] up_pc;
    logic            up_taken;
    logic [PC_W-1:0] up_target;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    branch_pred i_branch_pred (
        .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(lk_taken),
        .lk_target(lk_target), .up_valid(up_valid), .up_pc(up_pc),
        .up_taken(up_taken), .up_target(up_target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present a lookup on the falling edge, sample 1 ns later
    task automatic expect_pred(input string req, input logic [31:0] pc,
                               input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        lk_pc = pc;
        #1;
        check({req, " dir"}, {31'd0, lk_taken}, {31'd0, tk});
        check({req, " tgt"}, lk_target, tgt);
    endtask

    task automatic train(input logic [31:0] pc, input logic tk, input logic [31:0] tgt);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_taken = tk; up_target = tgt;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic t_reset;
        expect_pred("R1", 32'h0000_0000, 1'b0, 32'h0000_0004);
        expect_pred("R1", 32'h1234_5678, 1'b0, 32'h1234_567C);
        expect_pred("R7 wrap", 32'hFFFF_FFFC, 1'b0, 32'h0000_0000);
    endtask

    task automatic t_hysteresis;
        logic [31:0] p = 32'h0000_0200;
        logic [31:0] t = 32'h0000_8000;
        train(p, 1'b1, t);
        expect_pred("R3 weak taken", p, 1'b1, t);
        expect_pred("R9 neighbour", p + 4, 1'b0, p + 8);
        for (int k = 0; k < 3; k++) train(p, 1'b1, t);
        train(p, 1'b0, 32'h0000_0000);
        expect_pred("R5 one miss holds / R6 nt keeps tgt", p, 1'b1, t);
        train(p, 1'b0, 32'h0000_0000);
        expect_pred("R5 second miss flips / R7", p, 1'b0, p + 4);
    endtask

    task automatic t_floor;
        logic [31:0] p = 32'h0000_0300;
        logic [31:0] t = 32'h0000_9A40;
        for (int k = 0; k < 3; k++) train(p, 1'b0, 32'h0);
        train(p, 1'b1, t);
        expect_pred("R4 floor then one up", p, 1'b0, p + 4);
        train(p, 1'b1, t);
        expect_pred("R5 second taken flips", p, 1'b1, t);
    endtask

    task automatic t_retarget;
        logic [31:0] p = 32'h0000_0400;
        train(p, 1'b1, 32'h0000_A000);
        expect_pred("R6 first target", p, 1'b1, 32'h0000_A000);
        train(p, 1'b1, 32'h0000_B00C);
        expect_pred("R6 replaced target", p, 1'b1, 32'h0000_B00C);
        train(p, 1'b1, 32'h0000_C003);
        expect_pred("R6 low bits zero", p, 1'b1, 32'h0000_C000);
    endtask

    task automatic t_alias;
        logic [31:0] p = 32'h0000_0500;
        expect_pred("R7 unaligned seq", p + 1, 1'b0, p + 5);
        train(p | 32'h0000_4000, 1'b1, 32'h0000_D000);
        expect_pred("R2 high alias", p, 1'b1, 32'h0000_D000);
        expect_pred("R2 low bits alias", p + 2, 1'b1, 32'h0000_D000);
        expect_pred("R2 next slot", p + 4, 1'b0, p + 8);
    endtask

    task automatic t_same_cycle;
        logic [31:0] p = 32'h0000_0600;
        @(negedge clk);
        up_valid = 1'b1; up_pc = p; up_taken = 1'b1; up_target = 32'h0000_E000;
        lk_pc = p;
        #1;
        check("R8 no bypass dir", {31'd0, lk_taken}, 32'd0);
        check("R8 no bypass tgt", lk_target, p + 4);
        @(negedge clk);
        up_valid = 1'b0;
        #1;
        check("R8 next cycle dir", {31'd0, lk_taken}, 32'd1);
        check("R8 next cycle tgt", lk_target, 32'h0000_E000);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; lk_pc = '0; up_valid = 1'b0; up_pc = '0;
        up_taken = 1'b0; up_target = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hysteresis();
        t_floor();
        t_retarget();
        t_alias();
        t_same_cycle();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        expect_pred("R1 re-reset", 32'h0000_0400, 1'b0, 32'h0000_0404);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule